// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block serves one external interrupt request pin. The pin is brought into the clock domain through a chain of flops and watched for events of a chosen polarity. Two detection modes exist: edge-only, or edge plus held level. Each event sets a sticky flag. Software clears the flag by writing a one to an acknowledge bit of the block's single 8-bit control and status register. An interrupt output follows the flag whenever interrupts are enabled. The same register also drives two pad controls: a pull enable and a pull direction.

The register sits on a minimal synchronous bus. There is no address: a write strobe with eight data bits updates the register, and the read data always shows its current contents. In edge-and-level mode an acknowledge has no effect while the synchronised pin remains at its active level, so the flag stays set until the request is removed. Selecting rising or high activity also turns the pad pull from a pull-up into a pull-down.

Top module: `extint_ctrl`

## Requirements
- R1: While reset is applied, and once it is released, the read data is 0x00 and irq_o, pull_en_o and pull_down_o are all 0.
- R2: Register bit positions are: 6 pull disable, 5 polarity (1 = rising/high active, 0 = falling/low active), 4 pin enable, 3 event flag, 2 acknowledge, 1 interrupt enable, 0 level mode. Bits 6, 5, 4, 1 and 0 read back what was last written. Bits 7 and 2 always read 0, and a write never sets bit 3 directly.
- R3: With level mode at 0, only an edge toward the active level sets the flag. A falling edge does this when polarity is 0, and a rising edge when polarity is 1. An edge in the other direction leaves the flag unchanged.
- R4: With level mode at 1, the synchronised pin resting at the active level sets the flag. An acknowledge cannot clear the flag while that level persists. Once the pin has left the active level, an acknowledge clears it.
- R5: A write with bit 2 at 1 clears the flag when no event occurs in the same cycle. A write with bit 2 at 0 leaves the flag as it was.
- R6: When an event and an acknowledge occur in the same cycle, the flag stays set.
- R7: irq_o is 1 exactly when the flag and interrupt enable are both 1. With enable at 0 the flag remains visible in bit 3.
- R8: While pin enable is 0, no edge or level sets the flag.
- R9: pull_en_o is 1 only when pin enable is 1 and pull disable is 0. pull_down_o is 1 only when pull_en_o is 1 and polarity is 1.
- R10: A pin change is sampled by a two-flop chain. An active edge presented before rising clock edge k shows in bit 3 after edge k+2 and not after edge k+1.
- R11: Enabling the pin while it rests at its inactive level does not set the flag. Flipping polarity in edge mode while the pin is steady does not set the flag either.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 1 | Asynchronous external request pin |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| irq_o | output | 1 | Interrupt request to the CPU side |
| pull_en_o | output | 1 | Pad pull device enable |
| pull_down_o | output | 1 | Pad pull direction, 1 selects pull-down |

## Verification
The bench builds the block with its default parameters: a two-stage pin synchroniser and a two-stage reset release. With those values the flag's three-edge latency after a pin change is a fixed, known count. That lets the bench show that the flag is still clear after the second edge and set after the third. It also lets the bench place an acknowledge write on exactly the edge where an edge event is first seen, which is what proves that the event takes priority.

// File: rtl/extint_pkg.sv
package extint_pkg;

  localparam int unsigned REG_W = 8;

  // Register bit positions (software-visible layout)
  localparam int unsigned BIT_RSVD     = 7;
  localparam int unsigned BIT_PULL_DIS = 6;
  localparam int unsigned BIT_POL      = 5;
  localparam int unsigned BIT_PIN_EN   = 4;
  localparam int unsigned BIT_FLAG     = 3;
  localparam int unsigned BIT_ACK      = 2;
  localparam int unsigned BIT_IRQ_EN   = 1;
  localparam int unsigned BIT_LVL_MODE = 0;

  typedef struct packed {
    logic pull_dis;
    logic pol_high;
    logic pin_en;
    logic irq_en;
    logic lvl_mode;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '0;

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign stg_d[g] = d_i;
      end else begin : g_next
        assign stg_d[g] = stg_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/extint_detect.sv
module extint_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_i,
  input  logic pin_en_i,
  input  logic pol_high_i,
  input  logic lvl_mode_i,
  output logic evt_o
);

  logic prev_q;
  logic prev_d;
  logic at_active;
  logic edge_hit;

  // Event decode and previous-sample next state
  always_comb begin
    at_active = pol_high_i ? smp_i : ~smp_i;
    edge_hit  = at_active && (smp_i != prev_q);
    evt_o     = pin_en_i && (edge_hit || (lvl_mode_i && at_active));
    // While disabled, hold the inactive level so enabling never fakes an edge
    prev_d    = pin_en_i ? smp_i : ~pol_high_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
    end else begin
      prev_q <= prev_d;
    end
  end

endmodule

// File: rtl/extint_regs.sv
module extint_regs
  import extint_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             evt_i,
  output ctrl_t            ctrl_o,
  output logic             flag_o,
  output logic [REG_W-1:0] rd_data_o,
  output logic             irq_o
);

  ctrl_t ctrl_q;
  ctrl_t ctrl_d;
  logic  flag_q;
  logic  flag_d;
  logic  ack;
  logic  unused_wr_bits;

  assign ack            = wr_en_i && wr_data_i[BIT_ACK];
  assign unused_wr_bits = ^{wr_data_i[BIT_RSVD], wr_data_i[BIT_FLAG]};

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en_i) begin
      ctrl_d.pull_dis = wr_data_i[BIT_PULL_DIS];
      ctrl_d.pol_high = wr_data_i[BIT_POL];
      ctrl_d.pin_en   = wr_data_i[BIT_PIN_EN];
      ctrl_d.irq_en   = wr_data_i[BIT_IRQ_EN];
      ctrl_d.lvl_mode = wr_data_i[BIT_LVL_MODE];
    end
  end

  // A new event outranks an acknowledge in the same cycle
  always_comb begin
    flag_d = flag_q;
    if (evt_i) begin
      flag_d = 1'b1;
    end else if (ack) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RESET;
      flag_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rd_data_o               = '0;
    rd_data_o[BIT_PULL_DIS] = ctrl_q.pull_dis;
    rd_data_o[BIT_POL]      = ctrl_q.pol_high;
    rd_data_o[BIT_PIN_EN]   = ctrl_q.pin_en;
    rd_data_o[BIT_FLAG]     = flag_q;
    rd_data_o[BIT_IRQ_EN]   = ctrl_q.irq_en;
    rd_data_o[BIT_LVL_MODE] = ctrl_q.lvl_mode;
  end

  assign ctrl_o = ctrl_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q && ctrl_q.irq_en;

endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             irq_o,
  output logic             pull_en_o,
  output logic             pull_down_o
);

  logic  rst_core_n;
  logic  pin_smp;
  logic  evt;
  logic  flag;
  ctrl_t ctrl;

  extint_sync #(
    .STAGES (RST_STAGES),
    .RST_VAL(1'b0)
  ) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (1'b1),
    .q_o   (rst_core_n)
  );

  extint_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_core_n),
    .d_i   (pin_i),
    .q_o   (pin_smp)
  );

  extint_detect u_detect (
    .clk_i     (clk_i),
    .rst_ni    (rst_core_n),
    .smp_i     (pin_smp),
    .pin_en_i  (ctrl.pin_en),
    .pol_high_i(ctrl.pol_high),
    .lvl_mode_i(ctrl.lvl_mode),
    .evt_o     (evt)
  );

  extint_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_core_n),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .evt_i    (evt),
    .ctrl_o   (ctrl),
    .flag_o   (flag),
    .rd_data_o(rd_data_o),
    .irq_o    (irq_o)
  );

  // Pad controls: pull only when the pin is in use, direction follows polarity
  assign pull_en_o   = ctrl.pin_en && !ctrl.pull_dis;
  assign pull_down_o = pull_en_o && ctrl.pol_high;

endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk
  import extint_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             irq_o,
  input logic             pull_en_o,
  input logic             pull_down_o,
  input logic             evt_i
);

  a_r2_fixed_zero_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[BIT_RSVD] && !rd_data_o[BIT_ACK]);

  a_r4_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[BIT_FLAG] && !(wr_en_i && wr_data_i[BIT_ACK]) |=> rd_data_o[BIT_FLAG]);

  a_r5_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[BIT_ACK] && !evt_i |=> !rd_data_o[BIT_FLAG]);

  a_r6_event_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> rd_data_o[BIT_FLAG]);

  a_r7_irq_needs_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rd_data_o[BIT_FLAG] && rd_data_o[BIT_IRQ_EN]);

  a_r7_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[BIT_FLAG] && rd_data_o[BIT_IRQ_EN] |-> irq_o);

  a_r8_no_event_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[BIT_PIN_EN] |-> !evt_i);

  a_r9_pull_down_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_down_o |-> pull_en_o && rd_data_o[BIT_POL]);

  a_r9_pull_en_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_en_o |-> rd_data_o[BIT_PIN_EN] && !rd_data_o[BIT_PULL_DIS]);

endmodule

bind extint_ctrl extint_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .rd_data_o  (rd_data_o),
  .irq_o      (irq_o),
  .pull_en_o  (pull_en_o),
  .pull_down_o(pull_down_o),
  .evt_i      (evt)
);

// File: tb/extint_ctrl_tb.sv
`timescale 1ns/1ps
module extint_ctrl_tb_top;

  localparam int unsigned WD_LIMIT = 20000;
  localparam int unsigned NVEC     = 16;

  // {do_wr, wdata[7:0], pin, exp_rd[7:0], exp_irq, exp_pull_en, exp_pull_down}
  localparam logic [20:0] VECS [NVEC] = '{
    {1'b1, 8'h12, 1'b1, 8'h12, 1'b0, 1'b1, 1'b0},
    {1'b0, 8'h00, 1'b0, 8'h1A, 1'b1, 1'b1, 1'b0},
    {1'b1, 8'h16, 1'b0, 8'h12, 1'b0, 1'b1, 1'b0},
    {1'b0, 8'h00, 1'b1, 8'h12, 1'b0, 1'b1, 1'b0},
    {1'b1, 8'h32, 1'b1, 8'h32, 1'b0, 1'b1, 1'b1},
    {1'b0, 8'h00, 1'b0, 8'h32, 1'b0, 1'b1, 1'b1},
    {1'b0, 8'h00, 1'b1, 8'h3A, 1'b1, 1'b1, 1'b1},
    {1'b1, 8'h30, 1'b1, 8'h38, 1'b0, 1'b1, 1'b1},
    {1'b1, 8'h35, 1'b1, 8'h39, 1'b0, 1'b1, 1'b1},
    {1'b0, 8'h00, 1'b0, 8'h39, 1'b0, 1'b1, 1'b1},
    {1'b1, 8'h35, 1'b0, 8'h31, 1'b0, 1'b1, 1'b1},
    {1'b1, 8'h71, 1'b0, 8'h71, 1'b0, 1'b0, 1'b0},
    {1'b1, 8'h01, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0},
    {1'b0, 8'h00, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0},
    {1'b0, 8'h00, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0},
    {1'b1, 8'hFF, 1'b0, 8'h73, 1'b0, 1'b0, 1'b0}
  };

  logic       clk;
  logic       rst_n;
  logic       pin;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       irq;
  logic       pull_en;
  logic       pull_down;

  int checks;
  int errors;
  int cycles;

  extint_ctrl dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pin_i      (pin),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .rd_data_o  (rd_data),
    .irq_o      (irq),
    .pull_en_o  (pull_en),
    .pull_down_o(pull_down)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles == WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic string vec_req(int idx);
    case (idx)
      0, 4:         return "R11";
      1, 3, 5, 6:   return "R3";
      2:            return "R5";
      7:            return "R7";
      8, 9, 10:     return "R4";
      11:           return "R9";
      12, 13, 14:   return "R8";
      default:      return "R2";
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [7:0] d);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = 8'h00;
  endtask

  initial begin
    checks  = 0;
    errors  = 0;
    cycles  = 0;
    rst_n   = 1'b0;
    pin     = 1'b1;
    wr_en   = 1'b0;
    wr_data = 8'h00;
    step(3);
    rst_n = 1'b1;
    step(4);
    // R1: state after reset release
    chk("R1", rd_data, 8'h00);
    chk("R1", {5'd0, irq, pull_en, pull_down}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      pin = VECS[i][11];
      if (VECS[i][20]) reg_write(VECS[i][19:12]);
      step(4);
      chk(vec_req(i), rd_data, VECS[i][10:3]);
      chk("R7", {7'd0, irq}, {7'd0, VECS[i][2]});
      chk("R9", {6'd0, pull_en, pull_down}, {6'd0, VECS[i][1:0]});
    end

    // R1: asynchronous reset clears a populated register
    rst_n = 1'b0;
    pin   = 1'b1;
    step(1);
    chk("R1", rd_data, 8'h00);
    rst_n = 1'b1;
    step(4);

    // R11: enable with pin idle high, falling polarity
    reg_write(8'h10);
    step(4);
    chk("R11", rd_data, 8'h10);

    // R10: flag appears on the third rising edge after the pin change
    pin = 1'b0;
    step(2);
    chk("R10", rd_data, 8'h10);
    step(1);
    chk("R10", rd_data, 8'h18);

    // R5: acknowledge bit at 0 keeps the flag, at 1 clears it
    reg_write(8'h10);
    step(2);
    chk("R5", rd_data, 8'h18);
    reg_write(8'h14);
    step(2);
    chk("R5", rd_data, 8'h10);

    // R3: rising edge with falling polarity sets nothing
    pin = 1'b1;
    step(4);
    chk("R3", rd_data, 8'h10);

    // R6: acknowledge on the very edge the event is seen
    pin = 1'b0;
    step(2);
    reg_write(8'h14);
    step(2);
    chk("R6", rd_data, 8'h18);

    // R11: enable with rising polarity while pin rests low
    reg_write(8'h04);
    reg_write(8'h30);
    step(4);
    chk("R11", rd_data, 8'h30);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule